// File: doc/BRIEF.md
# Long-Format Translation Table Walker with One-Way Security Downgrade

This block resolves a 48-bit input address into an output address by walking a chain of 64-bit descriptors in memory, using a 4 KB granule in which every level resolves 9 address bits. A walk is launched with a table base value, a start level and the security state of the translation regime. The walker issues one read per level on a simple request/response port and follows table descriptors until it meets a page or a block. It then reports the output address and the final non-secure attribute, or a fault together with the level at which the walk stopped.

Each read carries a secure attribute. A walk that starts in a secure regime reads its first table as secure. Any table descriptor met on the way may switch the remainder of the walk to non-secure, and nothing can switch it back. A walk that starts in a non-secure regime stays non-secure throughout. The final attribute reported with a translation reflects every downgrade seen along the path and the leaf's own non-secure bit.

The memory port has no backpressure beyond the wait for a response. The request line and the address stay asserted until a response arrives. After the final descriptor the walker returns to idle and raises a one-cycle completion pulse.

Top module: `lfw_walker`

## Requirements
- R1: While reset is high and afterwards until a walk is started, `mem_req_o`, `busy_o` and `done_o` are 0.
- R2: The first read of a walk targets the table base formed from base-value bits [47:12], with bits [11:0] zero. Base-value bits [63:48] and [11:0] have no effect on any read address.
- R3: The read at level L (0..3) targets the current table base ORed with input-address bits [12+9*(3-L)+8 : 12+9*(3-L)] placed at address bits [11:3]. Address bits [2:0] are always 0.
- R4: At levels 0 to 2, a descriptor with bits [1:0] = 2'b11 is a table descriptor. The next read is at level L+1, and its table base is descriptor bits [47:12] with bits [11:0] zero.
- R5: A descriptor with bit 0 = 0 ends the walk with `fault_o` = 1 and `fault_lvl_o` = the level of that read.
- R6: A descriptor with bits [1:0] = 2'b01 is a fault at level 3 (reserved encoding) and at level 0 (no block allowed there). The fault level is reported as in R5.
- R7: At level 3, bits [1:0] = 2'b11 form a page. `out_addr_o` = {descriptor[47:12], input address[11:0]}.
- R8: At level 1 or 2, bits [1:0] = 2'b01 form a block. `out_addr_o` takes descriptor bits [47:30] (level 1) or [47:21] (level 2), and the remaining low bits come from the input address.
- R9: A non-secure flag starts at 0 for a secure regime (`secure_regime_i` = 1) and at 1 otherwise. It is ORed with bit 63 of every table descriptor. Each read drives `mem_secure_o` = 1 exactly when the flag is 0. Bit 63 of a leaf descriptor has no effect.
- R10: After a successful walk, `out_ns_o` is the OR of the accumulated flag and bit 5 of the leaf descriptor. Bit 5 of a table descriptor has no effect.
- R11: The request holds `mem_addr_o` and `mem_secure_o` stable until a response arrives. `done_o` is a one-cycle pulse, after which `busy_o` and `mem_req_o` are 0. `start_i` has no effect while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a walk (accepted only when idle) |
| va_i | input | 48 | Input address to translate |
| tbr_i | input | 64 | Translation table base value |
| start_lvl_i | input | 2 | Level of the first table |
| secure_regime_i | input | 1 | 1 = walk starts secure |
| mem_req_o | output | 1 | Descriptor read request, held until response |
| mem_addr_o | output | 48 | Descriptor read address |
| mem_secure_o | output | 1 | Read is issued as secure |
| mem_rsp_valid_i | input | 1 | Read data valid (one pulse per request) |
| mem_rsp_data_i | input | 64 | Descriptor read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_lvl_o | output | 2 | Level of the faulting read |
| out_addr_o | output | 48 | Translated output address |
| out_ns_o | output | 1 | Final non-secure attribute |

## Verification
The hardest case to reach from the ports is a secure walk that is downgraded partway down the chain. In such a walk the early reads must stay secure, every later read must stay non-secure, and the final attribute must differ from what the leaf alone would give. To reach it, the bench builds a fresh set of tables in a sparse memory model for each walk, with the NSTable bits set in every pattern across the table levels. It sweeps start level, leaf level, regime, leaf form and leaf NS bit. Junk is placed in the table NS bit, the leaf bit 63 and the base-value padding, so that a design that reads the wrong field is caught.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
  typedef enum logic {
    WS_IDLE  = 1'b0,
    WS_FETCH = 1'b1
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_INVALID  = 2'd0,
    DK_TABLE    = 2'd1,
    DK_LEAF     = 2'd2,
    DK_RESERVED = 2'd3
  } desc_kind_e;
endpackage

// File: rtl/lfw_addr_gen.sv
module lfw_addr_gen #(
  parameter int VA_W   = 48,
  parameter int OA_W   = 48,
  parameter int GRAN   = 12,
  parameter int STRIDE = 9,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2
) (
  input  logic [OA_W-1:0]  base_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [OA_W-1:0]  addr_o
);
  localparam int ENTRY_SH = 3;
  localparam int SLOT_W   = STRIDE + ENTRY_SH;

  logic [STRIDE-1:0] index;

  // Pick the 9-bit slice of the input address that this level resolves.
  always_comb begin
    index = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_i == LVL_W'(l)) index = va_i[GRAN + STRIDE*(LEVELS-1-l) +: STRIDE];
    end
  end

  // Entry offset is 8-byte aligned: low bits are always zero.
  assign addr_o = base_i | OA_W'({index, {ENTRY_SH{1'b0}}});
endmodule

// File: rtl/lfw_desc_decode.sv
module lfw_desc_decode
  import lfw_pkg::*;
#(
  parameter int VA_W          = 48,
  parameter int OA_W          = 48,
  parameter int DESC_W        = 64,
  parameter int GRAN          = 12,
  parameter int STRIDE        = 9,
  parameter int LEVELS        = 4,
  parameter int LVL_W         = 2,
  parameter int MIN_BLOCK_LVL = 1,
  parameter int NSTABLE_BIT   = 63,
  parameter int LEAF_NS_BIT   = 5
) (
  input  logic [DESC_W-1:0] desc_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [VA_W-1:0]   va_i,
  output desc_kind_e        kind_o,
  output logic [OA_W-1:0]   next_base_o,
  output logic [OA_W-1:0]   leaf_addr_o,
  output logic              nstable_o,
  output logic              leaf_ns_o
);
  localparam int LAST_LVL = LEVELS - 1;

  logic [OA_W-1:0] low_mask;

  always_comb begin
    if (!desc_i[0]) begin
      kind_o = DK_INVALID;
    end else if (lvl_i == LVL_W'(LAST_LVL)) begin
      kind_o = desc_i[1] ? DK_LEAF : DK_RESERVED;
    end else if (desc_i[1]) begin
      kind_o = DK_TABLE;
    end else if (int'(lvl_i) >= MIN_BLOCK_LVL) begin
      kind_o = DK_LEAF;
    end else begin
      kind_o = DK_RESERVED;
    end
  end

  // Size of the region mapped by a leaf at this level.
  always_comb begin
    low_mask = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lvl_i == LVL_W'(l))
        low_mask = (OA_W'(1) << (GRAN + STRIDE*(LEVELS-1-l))) - OA_W'(1);
    end
  end

  assign next_base_o = {desc_i[OA_W-1:GRAN], {GRAN{1'b0}}};
  assign leaf_addr_o = (desc_i[OA_W-1:0] & ~low_mask) | (OA_W'(va_i) & low_mask);
  assign nstable_o   = desc_i[NSTABLE_BIT];
  assign leaf_ns_o   = desc_i[LEAF_NS_BIT];
endmodule

// File: rtl/lfw_walker.sv
module lfw_walker
  import lfw_pkg::*;
#(
  parameter int VA_W          = 48,
  parameter int OA_W          = 48,
  parameter int TBR_W         = 64,
  parameter int DESC_W        = 64,
  parameter int GRAN          = 12,
  parameter int STRIDE        = 9,
  parameter int LEVELS        = 4,
  parameter int MIN_BLOCK_LVL = 1,
  parameter int NSTABLE_BIT   = 63,
  parameter int LEAF_NS_BIT   = 5,
  localparam int LVL_W        = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [TBR_W-1:0]  tbr_i,
  input  logic [LVL_W-1:0]  start_lvl_i,
  input  logic              secure_regime_i,
  output logic              mem_req_o,
  output logic [OA_W-1:0]   mem_addr_o,
  output logic              mem_secure_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DESC_W-1:0] mem_rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [LVL_W-1:0]  fault_lvl_o,
  output logic [OA_W-1:0]   out_addr_o,
  output logic              out_ns_o
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  va_q;
  logic [OA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             ns_q;

  desc_kind_e       kind;
  logic [OA_W-1:0]  next_base;
  logic [OA_W-1:0]  leaf_addr;
  logic             nstable;
  logic             leaf_ns;
  logic             accept;

  lfw_addr_gen #(
    .VA_W(VA_W), .OA_W(OA_W), .GRAN(GRAN), .STRIDE(STRIDE),
    .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_addr (
    .base_i(base_q), .va_i(va_q), .lvl_i(lvl_q), .addr_o(mem_addr_o)
  );

  lfw_desc_decode #(
    .VA_W(VA_W), .OA_W(OA_W), .DESC_W(DESC_W), .GRAN(GRAN), .STRIDE(STRIDE),
    .LEVELS(LEVELS), .LVL_W(LVL_W), .MIN_BLOCK_LVL(MIN_BLOCK_LVL),
    .NSTABLE_BIT(NSTABLE_BIT), .LEAF_NS_BIT(LEAF_NS_BIT)
  ) u_dec (
    .desc_i(mem_rsp_data_i), .lvl_i(lvl_q), .va_i(va_q),
    .kind_o(kind), .next_base_o(next_base), .leaf_addr_o(leaf_addr),
    .nstable_o(nstable), .leaf_ns_o(leaf_ns)
  );

  assign mem_req_o    = (state_q == WS_FETCH);
  assign busy_o       = (state_q == WS_FETCH);
  assign mem_secure_o = ~ns_q;
  assign accept       = (state_q == WS_FETCH) && mem_rsp_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WS_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      lvl_q       <= '0;
      ns_q        <= 1'b0;
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      fault_lvl_o <= '0;
      out_addr_o  <= '0;
      out_ns_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == WS_IDLE) begin
        if (start_i) begin
          state_q <= WS_FETCH;
          va_q    <= va_i;
          base_q  <= {tbr_i[OA_W-1:GRAN], {GRAN{1'b0}}};
          lvl_q   <= start_lvl_i;
          ns_q    <= ~secure_regime_i;
        end
      end else if (accept) begin
        unique case (kind)
          DK_TABLE: begin
            base_q <= next_base;
            lvl_q  <= lvl_q + LVL_W'(1);
            ns_q   <= ns_q | nstable;
          end
          DK_LEAF: begin
            state_q     <= WS_IDLE;
            done_o      <= 1'b1;
            fault_o     <= 1'b0;
            fault_lvl_o <= '0;
            out_addr_o  <= leaf_addr;
            out_ns_o    <= ns_q | leaf_ns;
          end
          default: begin
            state_q     <= WS_IDLE;
            done_o      <= 1'b1;
            fault_o     <= 1'b1;
            fault_lvl_o <= lvl_q;
            out_addr_o  <= '0;
            out_ns_o    <= ns_q;
          end
        endcase
      end
    end
  end

  // Request held with unchanged address and attribute until answered (R11).
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rsp_valid_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_secure_o)));

  // Completion is a single-cycle pulse (R11).
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // Once a read went out non-secure, later reads of the same walk stay non-secure (R9).
  assert_ns_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o) && !$past(mem_secure_o)) |-> !mem_secure_o);

  // Walk levels never go backwards within a walk (R4).
  assert_level_up_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && $past(mem_req_o)) |-> (lvl_q >= $past(lvl_q)));

  // A leaf fetched non-secure cannot yield a secure result (R10).
  assert_final_ns_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fault_o && $past(mem_req_o) && !$past(mem_secure_o)) |-> out_ns_o);
endmodule

// File: tb/lfw_walker_test.sv
module lfw_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [47:0] va_i = '0;
  logic [63:0] tbr_i = '0;
  logic [1:0]  start_lvl_i = '0;
  logic        secure_regime_i = 1'b0;
  logic        mem_req_o;
  logic [47:0] mem_addr_o;
  logic        mem_secure_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        busy_o, done_o, fault_o, out_ns_o;
  logic [1:0]  fault_lvl_o;
  logic [47:0] out_addr_o;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem [logic [47:0]];
  logic [47:0] exp_addr [4];
  logic        exp_sec  [4];

  always #5 clk = ~clk;

  lfw_walker uut (
    .clk(clk), .rst(rst), .start_i(start_i), .va_i(va_i), .tbr_i(tbr_i),
    .start_lvl_i(start_lvl_i), .secure_regime_i(secure_regime_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_secure_o(mem_secure_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o),
    .out_addr_o(out_addr_o), .out_ns_o(out_ns_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] slot(input logic [47:0] va, input int lvl);
    return ((va >> (12 + 9*(3-lvl))) & 48'h1FF) << 3;
  endfunction

  // One walk: build tables, run, check every read and the result.
  task automatic run_walk(input int n, input int s, input int lf, input bit secure,
                          input int pat, input int kind, input bit leafns);
    logic [47:0] va, oa, base, nb, exp_out;
    logic [63:0] d;
    bit          nsacc, exp_fault, exp_ns;
    int          nfetch, got, wcnt, lat, guard;
    mem.delete();
    va   = 48'(64'(n) * 64'h9E37_79B9_7F4A + 64'h1234_5678_9ABC);
    oa   = 48'(64'(n) * 64'h5851_F42D_4C95 + 64'h0F0F_A5A5_3C3C);
    base = 48'h0000_8000_0000 + 48'(n[7:0]) * 48'h1000;
    nsacc = !secure;
    for (int l = s; l < lf; l++) begin
      nb = 48'h0040_0000_0000 + (48'(l + 1) << 24) + 48'(n[7:0]) * 48'h1000;
      exp_addr[l-s] = base | slot(va, l);
      exp_sec[l-s]  = !nsacc;
      d = {pat[l-s] ? 1'b1 : 1'b0, 15'h2B1D, nb[47:12], 10'h2A8, 2'b11};
      mem[exp_addr[l-s]] = d;
      nsacc = nsacc | pat[l-s];
      base = nb;
    end
    exp_addr[lf-s] = base | slot(va, lf);
    exp_sec[lf-s]  = !nsacc;
    d = {1'b1, 15'h0, oa[47:12], 10'h300 | (10'(leafns) << 3), 2'b00};
    if (kind == 0) d[1:0] = (lf == 3) ? 2'b11 : 2'b01;
    else if (kind == 1) d[1:0] = 2'b10;
    else d[1:0] = 2'b01;
    mem[exp_addr[lf-s]] = d;
    nfetch    = lf - s + 1;
    exp_fault = (kind != 0) || (lf == 0);
    exp_ns    = nsacc | leafns;
    if (lf == 3)      exp_out = {oa[47:12], va[11:0]};
    else if (lf == 2) exp_out = {oa[47:21], va[20:0]};
    else              exp_out = {oa[47:30], va[29:0]};
    lat = 1 + (n % 3);

    @(negedge clk);
    va_i = va; start_lvl_i = 2'(s); secure_regime_i = secure;
    tbr_i = {16'hBEEF, base_init(n), 12'hABC};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    got = 0; wcnt = 0; guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 100) begin
        fails++; checks++;
        $display("FAIL R11: walk %0d hung, actual no done expected done", n);
        break;
      end
      if (mem_rsp_valid_i) begin
        mem_rsp_valid_i = 1'b0;
        if (!done_o) continue;
      end
      if (done_o) begin
        start_i = 1'b0;
        check("R5/R6 fault flag", 64'(fault_o), 64'(exp_fault));
        if (exp_fault) check("R5/R6 fault level", 64'(fault_lvl_o), 64'(lf));
        else begin
          check(lf == 3 ? "R7 page address" : "R8 block address", 64'(out_addr_o), 64'(exp_out));
          check("R10 final NS", 64'(out_ns_o), 64'(exp_ns));
        end
        check("R4 read count", 64'(got), 64'(nfetch));
        @(negedge clk);
        check("R11 idle after done", {62'b0, busy_o, mem_req_o}, 64'd0);
        check("R11 done pulse", 64'(done_o), 64'd0);
        break;
      end
      start_i = n[0];  // R11: start during a walk must be ignored
      if (mem_req_o) begin
        wcnt++;
        if (wcnt >= lat) begin
          wcnt = 0;
          if (got < nfetch) begin
            check(got == 0 ? "R2/R3 first read address" : "R3/R4 read address",
                  64'(mem_addr_o), 64'(exp_addr[got]));
            check("R9 read secure attribute", 64'(mem_secure_o), 64'(exp_sec[got]));
          end else begin
            check("R4 extra read", 64'(got), 64'(nfetch - 1));
          end
          mem_rsp_data_i  = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 64'h0;
          mem_rsp_valid_i = 1'b1;
          got++;
        end
      end
    end
    start_i = 1'b0;
  endtask

  function automatic logic [35:0] base_init(input int n);
    return 36'h0000_8000_0 + 36'(n[7:0]);
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {61'b0, mem_req_o, busy_o, done_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle after reset", {61'b0, mem_req_o, busy_o, done_o}, 64'd0);
    n = 0;
    for (int s = 0; s < 4; s++)
      for (int lf = s; lf < 4; lf++)
        for (int sec = 0; sec < 2; sec++)
          for (int pat = 0; pat < 8; pat++)
            for (int kind = 0; kind < 3; kind++)
              for (int lns = 0; lns < 2; lns++) begin
                if (kind == 2 && lf != 3) continue;
                if (pat >= (1 << (lf - s))) continue;
                run_walk(n, s, lf, sec[0], pat, kind, lns[0]);
                n++;
              end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R11: watchdog expired, actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule